// File: doc/BRIEF.md
# Exception and Interrupt Entry Unit

This unit sits beside a processor pipeline and decides, once per clock, whether control must leave the current instruction stream. It watches four synchronous fault sources (an illegal-opcode detector, an integer divide-by-zero detector, the exception flags reported by the floating-point unit, and a trap instruction that carries a 5-bit vector). It also watches a 4-bit maskable interrupt request. It picks one event, forms a 16-bit cause code and a handler address, and saves the return PC and the old status word into one of two save-register pairs. It then rewrites the status word and, one cycle later, asks the core to redirect its fetch PC.

Two nesting levels are supported. The first event is saved into the normal pair and marks the status word as "in exception". A second synchronous event raised while the first is being handled is saved into the fatal pair and marks the word as "in fatal handling". A third one stops the processor in a fatal-halt state that only reset clears. The unit also tracks a halt-by-instruction state, and an accepted interrupt ends that state. Software reads and writes the save registers, the cause register and the status word through a small system-register port.

Top module: `exc_entry`

## Requirements
- R1: After reset, the status word (index 5) reads 0x00008000 (only NP, bit 15, set). Indices 0 to 4 read zero, halt_state is 0 and redirect_valid is low.
- R2: Illegal opcode gives cause 0xFF90 and handler 0xFFFFFF90. Divide by zero gives 0xFF80 and 0xFFFFFF80. A trap with vector v gives cause 0xFFA0+v and handler 0xFFFFFFA0 for v<16 or 0xFFFFFFB0 for v>=16, and its return PC is cur_pc+INSN_BYTES (other events return to cur_pc).
- R3: fpu_flags is ordered {reserved-operand[5], invalid[4], zero-divide[3], overflow[2], underflow[1], precision[0]}. With fpu_req, any of bits 5:2 raises an exception with handler 0xFFFFFF60. The cause is 0xFF60 (bit 5), else 0xFF70 (bit 4), else 0xFF68 (bit 3), else 0xFF64. Bits 1:0 alone never raise one. While running, every flag reported with fpu_req is ORed into status bits 9:4 in the same order.
- R4: Among synchronous sources, illegal opcode wins over divide by zero, which wins over FPU, which wins over trap. Any synchronous exception wins over an interrupt in the same cycle.
- R5: With EP (bit 14) clear, an accepted event saves the return PC to index 0 and the pre-event status word to index 1. It writes its cause to bits 15:0 of the cause register (index 4) and sets EP and ID (bit 12).
- R6: With EP set, a synchronous exception saves to index 2 (PC) and index 3 (status). It writes the cause to bits 31:16 of index 4, sets NP and leaves the other mode bits as they were.
- R7: A synchronous exception while NP is set moves halt_state to 2 with no redirect and no register change. In state 2, every input except reset is ignored.
- R8: An interrupt is accepted only when ID, EP and NP are all clear and irq_lvl >= status bits 19:16. Its cause is 0xFE00+16*irq_lvl and its handler is 0xFFFFFE00+16*irq_lvl. The new status level is irq_lvl+1, saturating at 15.
- R9: redirect_valid is high, with redirect_pc equal to the handler, for exactly the cycle after each accepted event.
- R10: halt_req while running moves halt_state to 1 (0 running, 1 halted by instruction, 2 fatal). In state 1, synchronous requests and FPU flags are ignored. An accepted interrupt returns the unit to 0 and redirects. An event in the same cycle wins over halt_req.
- R11: Index 6 reads PROC_ID. Indices 7, 24, 25 and all others above 6 read zero. Writes reach indices 0, 1, 2, 3 and 5, and a status write keeps only bits 19:12 and 9:0. Writes to other indices are ignored. A write in a cycle that accepts an event is dropped. A status write is applied before same-cycle FPU flags are ORed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 32 | PC of the instruction at the decision point |
| trap_req | input | 1 | Trap instruction present |
| trap_vec | input | 5 | Trap vector |
| illegal_req | input | 1 | Illegal opcode detected |
| zdiv_req | input | 1 | Integer divide by zero detected |
| fpu_req | input | 1 | FPU flags valid this cycle |
| fpu_flags | input | 6 | FPU flags, order given in R3 |
| irq_req | input | 1 | Maskable interrupt pending |
| irq_lvl | input | 4 | Level of the pending interrupt |
| halt_req | input | 1 | Halt instruction executed |
| sr_idx | input | 5 | System-register index |
| sr_we | input | 1 | System-register write strobe |
| sr_wdata | input | 32 | System-register write data |
| sr_rdata | output | 32 | System-register read data (combinational) |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Fetch redirect target |
| halt_state | output | 2 | 0 running, 1 halted, 2 fatal halt |

## Verification
The bench builds the unit with PROC_ID = 0x00005A01 and INSN_BYTES = 4. A distinctive identifier then exposes any miswired read mux on index 6, and a trap return offset hard-wired to 2 would show up at once. Each random burst starts from reset with a random interrupt level and random mode bits. Both nesting levels, the fatal halt, the halt/interrupt wake-up and write-versus-event collisions are therefore all reached many times, next to a directed opening with literal expected values.

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter logic [31:0] PROC_ID    = 32'h0000_8100,
  parameter int          INSN_BYTES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cur_pc,
  input  logic        trap_req,
  input  logic [4:0]  trap_vec,
  input  logic        illegal_req,
  input  logic        zdiv_req,
  input  logic        fpu_req,
  input  logic [5:0]  fpu_flags,
  input  logic        irq_req,
  input  logic [3:0]  irq_lvl,
  input  logic        halt_req,
  input  logic [4:0]  sr_idx,
  input  logic        sr_we,
  input  logic [31:0] sr_wdata,
  output logic [31:0] sr_rdata,
  output logic        redirect_valid,
  output logic [31:0] redirect_pc,
  output logic [1:0]  halt_state
);
  localparam logic [31:0] PSW_WMASK = 32'h000F_F3FF;
  localparam logic [31:0] PSW_RESET = 32'h0000_8000;
  localparam logic [31:0] RET_OFS   = 32'(INSN_BYTES);

  logic [31:0] eipc, eipsw, fepc, fepsw, ecr, psw;
  logic [1:0]  hstate;
  logic        redir_q;
  logic [31:0] redir_pc_q;

  wire running = (hstate == 2'd0);
  wire asleep  = (hstate == 2'd1);
  wire dead    = (hstate == 2'd2);
  wire fpu_exc = fpu_req & (|fpu_flags[5:2]);
  wire sync_any = running & (illegal_req | zdiv_req | fpu_exc | trap_req);
  wire irq_ok  = (running | asleep) & irq_req & ~psw[12] & ~psw[14] & ~psw[15]
                 & (irq_lvl >= psw[19:16]);
  wire take_sync = sync_any & ~psw[15];
  wire go_fatal  = sync_any & psw[15];
  wire take_irq  = irq_ok & ~sync_any;
  wire enter     = take_sync | take_irq;
  wire use_fatal = take_sync & psw[14];
  wire is_trap   = ~illegal_req & ~zdiv_req & ~fpu_exc & trap_req;
  wire [31:0] flag_or = (running & fpu_req) ? {22'd0, fpu_flags, 4'd0} : 32'd0;

  logic [15:0] cause;
  logic [31:0] tgt_pc, ret_pc, psw_entry, psw_plain;

  always_comb begin
    cause  = {8'hFE, irq_lvl, 4'h0};
    tgt_pc = {24'hFFFFFE, irq_lvl, 4'h0};
    if (sync_any) begin
      if (illegal_req) begin
        cause = 16'hFF90; tgt_pc = 32'hFFFF_FF90;
      end else if (zdiv_req) begin
        cause = 16'hFF80; tgt_pc = 32'hFFFF_FF80;
      end else if (fpu_exc) begin
        tgt_pc = 32'hFFFF_FF60;
        if (fpu_flags[5])      cause = 16'hFF60;
        else if (fpu_flags[4]) cause = 16'hFF70;
        else if (fpu_flags[3]) cause = 16'hFF68;
        else                   cause = 16'hFF64;
      end else begin
        cause  = 16'hFFA0 + {11'd0, trap_vec};
        tgt_pc = 32'hFFFF_FFA0 | {27'd0, trap_vec[4], 4'd0};
      end
    end
  end

  assign ret_pc = (take_sync & is_trap) ? cur_pc + RET_OFS : cur_pc;

  always_comb begin
    psw_entry = psw | flag_or;
    if (use_fatal) psw_entry[15] = 1'b1;
    else begin
      psw_entry[14] = 1'b1;
      psw_entry[12] = 1'b1;
    end
    if (take_irq) psw_entry[19:16] = (irq_lvl == 4'hF) ? 4'hF : irq_lvl + 4'd1;
  end

  assign psw_plain = ((sr_we && sr_idx == 5'd5) ? (sr_wdata & PSW_WMASK) : psw) | flag_or;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eipc <= '0; eipsw <= '0; fepc <= '0; fepsw <= '0; ecr <= '0;
      psw <= PSW_RESET; hstate <= 2'd0; redir_q <= 1'b0; redir_pc_q <= '0;
    end else if (!dead) begin
      redir_q <= enter;
      if (enter) redir_pc_q <= tgt_pc;
      if (go_fatal)                               hstate <= 2'd2;
      else if (take_irq)                          hstate <= 2'd0;
      else if (running && halt_req && !take_sync) hstate <= 2'd1;
      if (enter) begin
        psw <= psw_entry;
        if (use_fatal) begin
          fepc <= ret_pc; fepsw <= psw; ecr[31:16] <= cause;
        end else begin
          eipc <= ret_pc; eipsw <= psw; ecr[15:0] <= cause;
        end
      end else if (!go_fatal) begin
        psw <= psw_plain;
        if (sr_we) begin
          case (sr_idx)
            5'd0: eipc  <= sr_wdata;
            5'd1: eipsw <= sr_wdata;
            5'd2: fepc  <= sr_wdata;
            5'd3: fepsw <= sr_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (sr_idx)
      5'd0: sr_rdata = eipc;
      5'd1: sr_rdata = eipsw;
      5'd2: sr_rdata = fepc;
      5'd3: sr_rdata = fepsw;
      5'd4: sr_rdata = ecr;
      5'd5: sr_rdata = psw;
      5'd6: sr_rdata = PROC_ID;
      default: sr_rdata = 32'd0;
    endcase
  end

  assign redirect_valid = redir_q;
  assign redirect_pc    = redir_pc_q;
  assign halt_state     = hstate;

  // R5
  redirect_ep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> psw[14]);
  // R2
  handler_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (&redirect_pc[31:9]));
  // R7
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_state == 2'd2) |=> (halt_state == 2'd2));
  // R7
  fatal_novec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_state == 2'd2) |-> !redirect_valid);
  // R10
  sleep_nofatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_state == 2'd1) |=> (halt_state != 2'd2));
endmodule

// File: tb/exc_entry_bench.sv
module exc_entry_bench;
  localparam logic [31:0] TB_ID    = 32'h0000_5A01;
  localparam int          TB_BYTES = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, trap_req, illegal_req, zdiv_req, fpu_req, irq_req, halt_req, sr_we;
  logic [31:0] cur_pc, sr_wdata;
  logic [4:0]  trap_vec, sr_idx;
  logic [5:0]  fpu_flags;
  logic [3:0]  irq_lvl;
  logic [31:0] sr_rdata, redirect_pc;
  logic        redirect_valid;
  logic [1:0]  halt_state;

  exc_entry #(.PROC_ID(TB_ID), .INSN_BYTES(TB_BYTES)) u_exc_entry (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .trap_req(trap_req), .trap_vec(trap_vec),
    .illegal_req(illegal_req), .zdiv_req(zdiv_req), .fpu_req(fpu_req), .fpu_flags(fpu_flags),
    .irq_req(irq_req), .irq_lvl(irq_lvl), .halt_req(halt_req), .sr_idx(sr_idx), .sr_we(sr_we),
    .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .halt_state(halt_state));

  int checks = 0;
  int failures = 0;

  logic [31:0] m_eipc, m_eipsw, m_fepc, m_fepsw, m_ecr, m_psw, m_rpc;
  int          m_h;
  logic        m_rv;
  string       m_tag;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [4:0] idx);
    case (idx)
      0: return m_eipc;
      1: return m_eipsw;
      2: return m_fepc;
      3: return m_fepsw;
      4: return m_ecr;
      5: return m_psw;
      6: return TB_ID;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_step();
    bit run, fexc, sync, irqok;
    logic [31:0] flags, c, h, ret, old;
    int lvl;
    m_rv = 1'b0;
    m_tag = "R11";
    if (!rst_n) begin
      m_eipc = 0; m_eipsw = 0; m_fepc = 0; m_fepsw = 0; m_ecr = 0;
      m_psw = 32'h8000; m_h = 0; m_tag = "R1";
      return;
    end
    if (m_h == 2) begin m_tag = "R7"; return; end
    run   = (m_h == 0);
    fexc  = fpu_req && (fpu_flags[5:2] != 0);
    sync  = run && (illegal_req || zdiv_req || fexc || trap_req);
    lvl   = int'(m_psw[19:16]);
    irqok = irq_req && !m_psw[12] && !m_psw[14] && !m_psw[15] && (int'(irq_lvl) >= lvl);
    flags = (run && fpu_req) ? (32'(fpu_flags) << 4) : 32'd0;
    if (sync && m_psw[15]) begin
      m_h = 2; m_tag = "R7";
    end else if (sync || irqok) begin
      ret = cur_pc;
      if (sync) begin
        if (illegal_req)   begin c = 'hFF90; h = 'hFFFFFF90; end
        else if (zdiv_req) begin c = 'hFF80; h = 'hFFFFFF80; end
        else if (fexc) begin
          h = 'hFFFFFF60;
          c = fpu_flags[5] ? 'hFF60 : fpu_flags[4] ? 'hFF70 : fpu_flags[3] ? 'hFF68 : 'hFF64;
        end else begin
          c = 'hFFA0 + trap_vec;
          h = 'hFFFFFFA0 + ((trap_vec >= 16) ? 16 : 0);
          ret = cur_pc + TB_BYTES;
        end
      end else begin
        c = 'hFE00 + irq_lvl * 16;
        h = 'hFFFFFE00 + irq_lvl * 16;
        m_h = 0;
      end
      old = m_psw;
      m_psw = m_psw | flags;
      if (sync && old[14]) begin
        m_fepc = ret; m_fepsw = old; m_ecr[31:16] = c[15:0];
        m_psw[15] = 1'b1; m_tag = "R6";
      end else begin
        m_eipc = ret; m_eipsw = old; m_ecr[15:0] = c[15:0];
        m_psw[14] = 1'b1; m_psw[12] = 1'b1;
        if (!sync) begin
          m_psw[19:16] = (irq_lvl == 15) ? 4'd15 : irq_lvl + 4'd1;
          m_tag = "R8";
        end else if (irqok || (illegal_req + zdiv_req + fexc + trap_req) > 1) m_tag = "R4";
        else if (fexc && !illegal_req && !zdiv_req) m_tag = "R3";
        else m_tag = "R2";
      end
      m_rv = 1'b1; m_rpc = h;
    end else begin
      if (sr_we) begin
        case (sr_idx)
          0: m_eipc = sr_wdata;
          1: m_eipsw = sr_wdata;
          2: m_fepc = sr_wdata;
          3: m_fepsw = sr_wdata;
          5: m_psw = sr_wdata & 32'h000FF3FF;
          default: ;
        endcase
      end
      m_psw = m_psw | flags;
      if (fpu_req && run) m_tag = "R3";
      if (run && halt_req) begin m_h = 1; m_tag = "R10"; end
    end
  endtask

  task automatic compare();
    string st;
    chk({"R9 redirect_valid ", m_tag}, {31'd0, redirect_valid}, {31'd0, m_rv});
    if (m_rv) chk({m_tag, " redirect_pc"}, redirect_pc, m_rpc);
    chk((m_h == 2) ? "R7 halt_state" : "R10 halt_state", {30'd0, halt_state}, 32'(m_h));
    st = (sr_idx == 0 || sr_idx == 1 || sr_idx == 4) ? "R5 sr_rdata" :
         (sr_idx == 2 || sr_idx == 3) ? "R6 sr_rdata" : "R11 sr_rdata";
    chk(st, sr_rdata, m_read(sr_idx));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    model_step();
    compare();
    sr_we = 1'b0; trap_req = 1'b0; illegal_req = 1'b0; zdiv_req = 1'b0;
    fpu_req = 1'b0; irq_req = 1'b0; halt_req = 1'b0;
  endtask

  task automatic idle_inputs();
    trap_req = 0; trap_vec = 0; illegal_req = 0; zdiv_req = 0; fpu_req = 0; fpu_flags = 0;
    irq_req = 0; irq_lvl = 0; halt_req = 0; sr_idx = 5; sr_we = 0; sr_wdata = 0; cur_pc = 0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired checks=%0d", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    m_h = 0; m_rv = 0; m_rpc = 0; m_psw = 32'h8000;
    cyc(); cyc();
    rst_n = 1'b1;
    sr_idx = 5;
    cyc();
    chk("R1 reset status word", sr_rdata, 32'h0000_8000);
    chk("R1 reset halt_state", {30'd0, halt_state}, 32'd0);
    sr_we = 1; sr_idx = 5; sr_wdata = 32'h0;
    cyc();
    illegal_req = 1; cur_pc = 32'h0000_1000; sr_idx = 4;
    cyc();
    chk("R2 illegal handler", redirect_pc, 32'hFFFF_FF90);
    chk("R5 cause low half", sr_rdata, 32'h0000_FF90);
    trap_req = 1; trap_vec = 5'd17; cur_pc = 32'h0000_2000; sr_idx = 2;
    cyc();
    chk("R6 fatal pair pc with trap offset", sr_rdata, 32'h0000_2004);
    chk("R2 trap high vector handler", redirect_pc, 32'hFFFF_FFB0);
    zdiv_req = 1; sr_idx = 5;
    cyc();
    chk("R7 fatal halt", {30'd0, halt_state}, 32'd2);
    sr_idx = 6;
    cyc();
    chk("R11 processor id", sr_rdata, TB_ID);

    for (int b = 0; b < 30; b++) begin
      rst_n = 1'b0;
      cyc();
      rst_n = 1'b1;
      sr_we = 1; sr_idx = 5; sr_wdata = $urandom & 32'h000F_13FF;
      cyc();
      for (int k = 0; k < 250; k++) begin
        int r;
        cur_pc      = $urandom & 32'hFFFF_FFFE;
        illegal_req = ($urandom % 14) == 0;
        zdiv_req    = ($urandom % 14) == 0;
        trap_req    = ($urandom % 10) == 0;
        trap_vec    = 5'($urandom);
        fpu_req     = ($urandom % 6) == 0;
        fpu_flags   = 6'($urandom);
        irq_req     = ($urandom % 3) == 0;
        irq_lvl     = 4'($urandom);
        halt_req    = ($urandom % 20) == 0;
        r = $urandom % 12;
        sr_idx = (r < 8) ? 5'(r) : (r == 8) ? 5'd24 : (r == 9) ? 5'd25 : (r == 10) ? 5'd31 : 5'd5;
        sr_we    = ($urandom % 5) == 0;
        sr_wdata = $urandom;
        if (sr_idx == 5 && ($urandom % 4) != 0) sr_wdata = sr_wdata & 32'hFFFF_2FFF;
        cyc();
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule